// File: doc/BRIEF.md
# Dual-Gain PI Voltage Regulator

This block is a fixed-point proportional-integral regulator for the outer voltage loop of a power converter. On each strobe it takes one signed error sample, a target value and a heavily filtered bus measurement. It picks one of two gain pairs from the size of the error. It updates a saturating integrator and returns a scaled, saturated control word with a single-cycle valid pulse.

When the error is small, the regulator uses a fine gain pair. It drives that pair with a steady-state error, formed as the target minus the filtered measurement reduced by six bit positions. This lets the slow, low-noise filtered value set the operating point. When the error is large, a coarse gain pair acts directly on the raw error, so the loop recovers quickly from a load step. Only the integrator keeps state. A synchronous clear empties the integrator and cancels every result still in the pipeline.

Top module: `vloop_pi_dual`

## Requirements
- R1: When |err_i| < thresh_i (unsigned compare), the fine gains are used and the applied error is target_i minus (bus_filt_i >> 6), with the six low bits of bus_filt_i discarded.
- R2: When |err_i| >= thresh_i, including equality, the coarse gains are used and the applied error is err_i itself.
- R3: Every update adds ki times the applied error to the integrator and limits the result to at most integ_hi_i.
- R4: The same update limits the integrator to at least integ_lo_i.
- R5: The output is (kp * applied error + updated integrator) shifted right arithmetically by 12, so negative sums round toward minus infinity (a sum of -1 gives -1).
- R6: The shifted value is limited to the range out_lo_i to out_hi_i before it is presented on y_o.
- R7: The proportional term is not held between updates; a sample with zero applied error and zero ki returns exactly the integrator contribution.
- R8: clr forces the integrator to zero, drops y_valid_o in the next cycle and discards every result still in flight, including a strobe given in the same cycle as clr.
- R9: y_valid_o pulses once for each accepted strobe, exactly LAT = 2 + SEL_REG clock edges after the edge that samples the strobe; back-to-back strobes give back-to-back results.
- R10: Intermediate products and sums are at least 48 bits wide, so full-scale negative errors and gains give correctly saturated results without wrap-around.
- R11: After reset, y_valid_o is 0 and y_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of integrator and pipeline |
| stb | input | 1 | Update strobe; inputs sampled on this edge |
| err_i | input | EW | Signed raw error sample |
| target_i | input | TW | Unsigned voltage target |
| bus_filt_i | input | BW | Unsigned filtered bus value, FSH fraction bits |
| thresh_i | input | EW | Unsigned gain-switch threshold |
| kp_fine_i | input | CW | Signed Q15 proportional gain, small-error set |
| ki_fine_i | input | CW | Signed Q15 integral gain, small-error set |
| kp_coarse_i | input | CW | Signed Q15 proportional gain, large-error set |
| ki_coarse_i | input | CW | Signed Q15 integral gain, large-error set |
| integ_lo_i | input | IW | Signed integrator lower limit |
| integ_hi_i | input | IW | Signed integrator upper limit |
| out_lo_i | input | OW | Signed output lower limit |
| out_hi_i | input | OW | Signed output upper limit |
| y_o | output | OW | Saturated control output |
| y_valid_o | output | 1 | One-cycle result valid pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit error, a 12-bit target, an 18-bit filtered bus with 6 fraction bits, 16-bit Q15 gains, 32-bit integrator limits, a 48-bit datapath and the registered gain-selection stage (three-edge latency). With these widths, a full-scale -32768 error times a -32768 gain, added to a rail-level integrator, can be reached. So can the exact threshold boundary in both signs, the floor behaviour of the arithmetic shift on small negative sums, and a clear that lands on a result in flight.

// File: rtl/vloop_pi_pkg.sv
package vloop_pi_pkg;
   // Which gain pair an update used.
   typedef enum logic {
      GAIN_FINE   = 1'b0,
      GAIN_COARSE = 1'b1
   } gain_sel_e;

   // Minimum internal datapath width for products and sums.
   localparam int unsigned MIN_ACC_W = 48;
endpackage

// File: rtl/vloop_pi_sel.sv
module vloop_pi_sel
   import vloop_pi_pkg::*;
#(
   parameter int unsigned EW      = 16,
   parameter int unsigned TW      = 12,
   parameter int unsigned BW      = 18,
   parameter int unsigned FSH     = 6,
   parameter int unsigned CW      = 16,
   parameter int unsigned AW      = 48,
   parameter int unsigned SEL_REG = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 stb,
   input  logic signed [EW-1:0] err_i,
   input  logic        [TW-1:0] tgt_i,
   input  logic        [BW-1:0] bus_i,
   input  logic        [EW-1:0] thr_i,
   input  logic signed [CW-1:0] kp_f_i,
   input  logic signed [CW-1:0] ki_f_i,
   input  logic signed [CW-1:0] kp_c_i,
   input  logic signed [CW-1:0] ki_c_i,
   output logic                 vld_o,
   output logic signed [AW-1:0] e_o,
   output logic signed [CW-1:0] kp_o,
   output logic signed [CW-1:0] ki_o
);
   logic signed [AW-1:0] err_x, mag, fine_e, e_n;
   logic        [AW-1:0] thr_x, bus_x;
   logic signed [CW-1:0] kp_n, ki_n;
   gain_sel_e            mode;

   always_comb begin
      err_x  = {{(AW-EW){err_i[EW-1]}}, err_i};
      mag    = err_x[AW-1] ? -err_x : err_x;
      thr_x  = {{(AW-EW){1'b0}}, thr_i};
      bus_x  = {{(AW-BW){1'b0}}, bus_i};
      fine_e = $signed({{(AW-TW){1'b0}}, tgt_i}) - $signed(bus_x >> FSH);
      mode   = ($unsigned(mag) < thr_x) ? GAIN_FINE : GAIN_COARSE;
      if (mode == GAIN_FINE) begin
         e_n  = fine_e;
         kp_n = kp_f_i;
         ki_n = ki_f_i;
      end else begin
         e_n  = err_x;
         kp_n = kp_c_i;
         ki_n = ki_c_i;
      end
   end

   generate
      if (SEL_REG != 0) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_o <= 1'b0;
               e_o   <= '0;
               kp_o  <= '0;
               ki_o  <= '0;
            end else begin
               vld_o <= stb & ~clr;
               if (stb) begin
                  e_o  <= e_n;
                  kp_o <= kp_n;
                  ki_o <= ki_n;
               end
            end
         end
      end else begin : g_comb
         always_comb begin
            vld_o = stb & ~clr;
            e_o   = e_n;
            kp_o  = kp_n;
            ki_o  = ki_n;
         end
      end
   endgenerate
endmodule

// File: rtl/vloop_pi_integ.sv
module vloop_pi_integ #(
   parameter int unsigned CW = 16,
   parameter int unsigned IW = 32,
   parameter int unsigned AW = 48
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 vld_i,
   input  logic signed [AW-1:0] e_i,
   input  logic signed [CW-1:0] kp_i,
   input  logic signed [CW-1:0] ki_i,
   input  logic signed [IW-1:0] lo_i,
   input  logic signed [IW-1:0] hi_i,
   output logic                 vld_o,
   output logic signed [AW-1:0] p_o,
   output logic signed [AW-1:0] i_o
);
   logic signed [AW-1:0] kp_x, ki_x, lo_x, hi_x, acc, acc_sat, p_n;

   always_comb begin
      kp_x = {{(AW-CW){kp_i[CW-1]}}, kp_i};
      ki_x = {{(AW-CW){ki_i[CW-1]}}, ki_i};
      lo_x = {{(AW-IW){lo_i[IW-1]}}, lo_i};
      hi_x = {{(AW-IW){hi_i[IW-1]}}, hi_i};
      p_n  = kp_x * e_i;
      acc  = i_o + ki_x * e_i;
      if (acc > hi_x)      acc_sat = hi_x;
      else if (acc < lo_x) acc_sat = lo_x;
      else                 acc_sat = acc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         p_o   <= '0;
         i_o   <= '0;
      end else if (clr) begin
         vld_o <= 1'b0;
         i_o   <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            p_o <= p_n;
            i_o <= acc_sat;
         end
      end
   end
endmodule

// File: rtl/vloop_pi_out.sv
module vloop_pi_out #(
   parameter int unsigned OW  = 16,
   parameter int unsigned AW  = 48,
   parameter int unsigned OSH = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 vld_i,
   input  logic signed [AW-1:0] p_i,
   input  logic signed [AW-1:0] i_i,
   input  logic signed [OW-1:0] lo_i,
   input  logic signed [OW-1:0] hi_i,
   output logic signed [OW-1:0] y_o,
   output logic                 vld_o
);
   logic signed [AW-1:0] sum, sh, lo_x, hi_x;
   logic signed [OW-1:0] y_n;

   assign sum = p_i + i_i;

   generate
      if (OSH == 0) begin : g_noshift
         assign sh = sum;
      end else begin : g_shift
         assign sh = sum >>> OSH;
      end
   endgenerate

   always_comb begin
      lo_x = {{(AW-OW){lo_i[OW-1]}}, lo_i};
      hi_x = {{(AW-OW){hi_i[OW-1]}}, hi_i};
      if (sh > hi_x)      y_n = hi_i;
      else if (sh < lo_x) y_n = lo_i;
      else                y_n = sh[OW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         y_o   <= '0;
      end else if (clr) begin
         vld_o <= 1'b0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) y_o <= y_n;
      end
   end
endmodule

// File: rtl/vloop_pi_dual.sv
module vloop_pi_dual
   import vloop_pi_pkg::*;
#(
   parameter int unsigned EW      = 16,
   parameter int unsigned TW      = 12,
   parameter int unsigned BW      = 18,
   parameter int unsigned FSH     = 6,
   parameter int unsigned CW      = 16,
   parameter int unsigned IW      = 32,
   parameter int unsigned OW      = 16,
   parameter int unsigned AW      = 48,
   parameter int unsigned OSH     = 12,
   parameter int unsigned SEL_REG = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 stb,
   input  logic signed [EW-1:0] err_i,
   input  logic        [TW-1:0] target_i,
   input  logic        [BW-1:0] bus_filt_i,
   input  logic        [EW-1:0] thresh_i,
   input  logic signed [CW-1:0] kp_fine_i,
   input  logic signed [CW-1:0] ki_fine_i,
   input  logic signed [CW-1:0] kp_coarse_i,
   input  logic signed [CW-1:0] ki_coarse_i,
   input  logic signed [IW-1:0] integ_lo_i,
   input  logic signed [IW-1:0] integ_hi_i,
   input  logic signed [OW-1:0] out_lo_i,
   input  logic signed [OW-1:0] out_hi_i,
   output logic signed [OW-1:0] y_o,
   output logic                 y_valid_o
);
   localparam int unsigned LAT   = 2 + SEL_REG;
   localparam int unsigned ERR_W = ((EW > TW + 1) ? EW : TW + 1) + 1;
   localparam int unsigned NEED  = ((CW + ERR_W > IW) ? CW + ERR_W : IW) + 2;

   generate
      if (AW < MIN_ACC_W) begin : g_chk_aw
         $error("datapath width AW below minimum");
      end
      if (AW < NEED) begin : g_chk_need
         $error("AW too narrow for gain, error and limit widths");
      end
      if (BW <= FSH || OSH >= AW || OW > IW || AW <= BW) begin : g_chk_geom
         $error("inconsistent width or shift parameters");
      end
      if (SEL_REG > 1) begin : g_chk_sel
         $error("SEL_REG must be 0 or 1");
      end
   endgenerate

   logic                 s_vld, v_int;
   logic signed [AW-1:0] s_e, p_q, i_q;
   logic signed [CW-1:0] s_kp, s_ki;

   vloop_pi_sel #(
      .EW(EW), .TW(TW), .BW(BW), .FSH(FSH), .CW(CW), .AW(AW), .SEL_REG(SEL_REG)
   ) sel_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .stb(stb),
      .err_i(err_i), .tgt_i(target_i), .bus_i(bus_filt_i), .thr_i(thresh_i),
      .kp_f_i(kp_fine_i), .ki_f_i(ki_fine_i), .kp_c_i(kp_coarse_i), .ki_c_i(ki_coarse_i),
      .vld_o(s_vld), .e_o(s_e), .kp_o(s_kp), .ki_o(s_ki)
   );

   vloop_pi_integ #(.CW(CW), .IW(IW), .AW(AW)) integ_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .vld_i(s_vld),
      .e_i(s_e), .kp_i(s_kp), .ki_i(s_ki), .lo_i(integ_lo_i), .hi_i(integ_hi_i),
      .vld_o(v_int), .p_o(p_q), .i_o(i_q)
   );

   vloop_pi_out #(.OW(OW), .AW(AW), .OSH(OSH)) out_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .vld_i(v_int),
      .p_i(p_q), .i_i(i_q), .lo_i(out_lo_i), .hi_i(out_hi_i),
      .y_o(y_o), .vld_o(y_valid_o)
   );
endmodule

// File: rtl/vloop_pi_chk.sv
module vloop_pi_chk #(
   parameter int unsigned AW  = 48,
   parameter int unsigned IW  = 32,
   parameter int unsigned OW  = 16,
   parameter int unsigned LAT = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 clr,
   input logic                 stb,
   input logic                 ivld,
   input logic signed [AW-1:0] integ,
   input logic signed [IW-1:0] ilo,
   input logic signed [IW-1:0] ihi,
   input logic                 yvld,
   input logic signed [OW-1:0] y,
   input logic signed [OW-1:0] olo,
   input logic signed [OW-1:0] ohi
);
   // R3: integrator never above the upper limit in force at its update
   a_r3_integ_high: assert property (@(posedge clk) disable iff (!rst_n)
      ivld |-> integ <= $past(ihi));

   // R4: integrator never below the lower limit in force at its update
   a_r4_integ_low: assert property (@(posedge clk) disable iff (!rst_n)
      ivld |-> integ >= $past(ilo));

   // R6: presented result lies inside the output limits
   a_r6_out_range: assert property (@(posedge clk) disable iff (!rst_n)
      yvld |-> (y <= $past(ohi)) && (y >= $past(olo)));

   // R8: clear empties integrator and kills the valid pulse
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !yvld && (integ == '0));

   // R9: every valid pulse traces back to a strobe LAT edges earlier
   a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
      yvld |-> $past(stb, LAT));
endmodule

bind vloop_pi_dual vloop_pi_chk #(.AW(AW), .IW(IW), .OW(OW), .LAT(LAT)) chk_i (
   .clk(clk), .rst_n(rst_n), .clr(clr), .stb(stb),
   .ivld(v_int), .integ(i_q), .ilo(integ_lo_i), .ihi(integ_hi_i),
   .yvld(y_valid_o), .y(y_o), .olo(out_lo_i), .ohi(out_hi_i)
);

// File: tb/vloop_pi_dual_tb.sv
module vloop_pi_dual_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 3;

   logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, stb = 1'b0;
   logic signed [15:0] err_s = '0;
   logic        [11:0] tgt = '0;
   logic        [17:0] bus = '0;
   logic        [15:0] thr = 16'd100;
   logic signed [15:0] kp_f = 16'sd1000, ki_f = 16'sd200, kp_c = 16'sd8000, ki_c = 16'sd3000;
   logic signed [31:0] ilo = -32'sd2147483647, ihi = 32'sd2147483647;
   logic signed [15:0] olo = -16'sd32768, ohi = 16'sd32767;
   logic signed [15:0] y;
   logic               yv;

   int n_run = 0, n_fail = 0, cyc = 0;
   longint m_integ = 0;

   typedef struct { longint exp_y; int at; string tag; } item_t;
   item_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   vloop_pi_dual dut_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .stb(stb), .err_i(err_s),
      .target_i(tgt), .bus_filt_i(bus), .thresh_i(thr),
      .kp_fine_i(kp_f), .ki_fine_i(ki_f), .kp_coarse_i(kp_c), .ki_coarse_i(ki_c),
      .integ_lo_i(ilo), .integ_hi_i(ihi), .out_lo_i(olo), .out_hi_i(ohi),
      .y_o(y), .y_valid_o(yv)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Reference arithmetic taken from the requirements.
   function automatic longint model(input int e_in, input int t, input int b);
      longint e, kp_v, ki_v, mag, s;
      mag = (e_in < 0) ? -longint'(e_in) : longint'(e_in);
      if (mag < longint'(thr)) begin          // R1
         e = longint'(t) - longint'(b / 64);
         kp_v = longint'(kp_f); ki_v = longint'(ki_f);
      end else begin                          // R2
         e = longint'(e_in);
         kp_v = longint'(kp_c); ki_v = longint'(ki_c);
      end
      m_integ = m_integ + ki_v * e;
      if (m_integ > longint'(ihi)) m_integ = longint'(ihi);       // R3
      if (m_integ < longint'(ilo)) m_integ = longint'(ilo);       // R4
      s = (kp_v * e + m_integ) >>> 12;                              // R5
      if (s > longint'(ohi)) s = longint'(ohi);                    // R6
      if (s < longint'(olo)) s = longint'(olo);
      return s;
   endfunction

   // Driver: one strobe per call, consecutive calls give back-to-back strobes.
   task automatic issue(input int e, input int t, input int b, input string tag);
      item_t it;
      @(negedge clk);
      err_s = 16'(e); tgt = 12'(t); bus = 18'(b); stb = 1'b1;
      it.exp_y = model(e, t, b); it.at = cyc; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      stb = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic do_clear();
      @(negedge clk);
      stb = 1'b0; clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      m_integ = 0;
   endtask

   // Monitor: pops and compares results, also checks R9 latency.
   always @(negedge clk) begin
      if (rst_n && yv) begin
         if (sb.size() == 0) begin
            check(1'b0, "R8/R9 unexpected valid", longint'(y), 0);
         end else begin
            item_t it;
            it = sb.pop_front();
            check(longint'(y) == it.exp_y, it.tag, longint'(y), it.exp_y);
            check(cyc - it.at == LAT, "R9 latency", cyc - it.at, LAT);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(yv == 1'b0, "R11 valid after reset", yv, 0);
      check(y == 16'sd0, "R11 output after reset", y, 0);

      // R1: small error, steady error uses target - bus>>6, low bits dropped
      issue(40, 3000, (1000 << 6) | 63, "R1 fine gains");
      issue(-5, 500, (800 << 6) | 1, "R1 fine negative");
      // R1/R2 threshold boundary
      issue(99, 2048, 2000 << 6, "R1 boundary 99");
      issue(100, 2048, 2000 << 6, "R2 boundary 100");
      issue(-100, 2048, 2000 << 6, "R2 boundary -100");
      issue(-99, 2048, 2000 << 6, "R1 boundary -99");
      issue(-3000, 0, 0, "R2 coarse negative");
      idle(6);

      // R3/R6: integrator and output high saturation
      do_clear();
      ihi = 32'sd1000000; ohi = 16'sd2000; ki_c = 16'sd30000;
      issue(1000, 0, 0, "R3 integ high 1");
      issue(1000, 0, 0, "R3 integ high 2");
      issue(1000, 0, 0, "R6 out high");
      idle(6);

      // R4/R6: low saturation
      ilo = -32'sd500000; olo = -16'sd300;
      issue(-1000, 0, 0, "R4 integ low 1");
      issue(-1000, 0, 0, "R4 integ low 2");
      issue(-1000, 0, 0, "R6 out low");
      idle(6);
      ilo = -32'sd2147483647; ihi = 32'sd2147483647;
      olo = -16'sd32768; ohi = 16'sd32767;

      // R5: arithmetic shift floors negative sums
      do_clear();
      thr = 16'd0; kp_c = 16'sd1; ki_c = 16'sd0;
      issue(-1, 0, 0, "R5 floor -1");
      issue(1, 0, 0, "R5 small positive");
      issue(-4097, 0, 0, "R5 floor -4097");
      idle(6);

      // R7: proportional term not held
      kp_c = 16'sd20000;
      issue(3000, 0, 0, "R7 large p");
      issue(0, 0, 0, "R7 p released");
      idle(6);

      // R8: clear cancels a result in flight; integrator restarts at zero
      ki_c = 16'sd20000;
      issue(2000, 0, 0, "R8 build integ");
      idle(5);
      issue(2000, 0, 0, "R8 dropped");
      @(negedge clk);
      stb = 1'b0; clr = 1'b1;
      void'(sb.pop_back());
      m_integ = 0;
      @(negedge clk);
      clr = 1'b0;
      check(yv == 1'b0, "R8 valid low after clear", yv, 0);
      repeat (5) @(negedge clk);
      kp_c = 16'sd0; ki_c = 16'sd0;
      issue(5, 0, 0, "R8 integ zero after clear");
      idle(6);

      // R9: back-to-back strobes with mixed modes
      thr = 16'd50; kp_c = 16'sd6000; ki_c = 16'sd700; kp_f = -16'sd1200; ki_f = 16'sd90;
      for (int k = 0; k < 6; k++)
         issue((k * 37) - 90, 100 * k, (50 * k) << 6, "R9 back-to-back");
      idle(8);

      // R10: full-scale products and rails
      do_clear();
      thr = 16'd0; kp_c = -16'sd32768; ki_c = 16'sd32767;
      for (int k = 0; k < 4; k++)
         issue(-32768, 0, 0, "R10 full scale");
      kp_c = 16'sd32767;
      issue(-32768, 0, 0, "R10 mixed sign");
      idle(8);

      check(sb.size() == 0, "R9 all results seen", sb.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule